// File: doc/BRIEF.md
# Two-Lane Synchronous FIFO With Per-Lane Occupancy Flags

This block is a single-clock first-in first-out buffer that can take up to two entries and hand out up to two entries in the same clock cycle. Each write lane has an enable and a data word. Each read lane has an enable and returns a data word with a valid strobe one cycle later. One occupancy counter covers the whole buffer. On every edge where any lane is accepted, the counter moves by a signed net change between -2 and +2.

Each lane has its own empty and full flag. The flags come from the occupancy held in the count register, so they describe the state at the start of the current cycle and take no account of traffic in that cycle. A lane whose flag blocks it is refused. A refused write is dropped. A refused read returns nothing and leaves the read position unchanged. A separate underrun indicator shows that a read was requested on a lane that had no data available. The storage is an internal ring whose depth is a parameter, and both ring positions wrap modulo that depth.

Top module: `duo_fifo`

## Requirements
- R1: While reset is held and in the first cycle after it, `count` is 0, `empty` is 2'b11, `full` is 2'b00, `rd_valid` is 2'b00 and `rd_underrun` is 0.
- R2: At each rising edge, `count` becomes its current value plus the number of accepted writes minus the number of accepted reads. A write on lane i is accepted when `wr_en[i]` is 1 and `full[i]` is 0. A read on lane i is accepted when `rd_en[i]` is 1 and `empty[i]` is 0.
- R3: `empty[i]` is 1 exactly when `count` <= i. `full[i]` is 1 exactly when `count` >= DEPTH - i. Both take their value from the registered count and ignore requests in the current cycle. `count` never exceeds DEPTH.
- R4: A write on a lane whose `full` bit is 1 is dropped. It does not change `count`, and its data never appears on a read port.
- R5: A read on a lane whose `empty` bit is 1 produces no `rd_valid` pulse on that lane and does not consume an entry. The next accepted read still returns the oldest stored word.
- R6: `rd_underrun` is 1 in a cycle exactly when some lane i has `rd_en[i]` = 1 and `empty[i]` = 1 in that same cycle.
- R7: Words leave in the order they were accepted. When both write lanes are accepted in one cycle, the lane 0 word is older. When both read lanes are accepted, lane 0 returns the oldest word and lane 1 the next oldest. A lane 1 read accepted alone returns the oldest word.
- R8: An accepted read on lane i raises `rd_valid[i]` with the word on `rd_data0`/`rd_data1` exactly one cycle after the request. In all other cycles `rd_valid[i]` is 0.
- R9: The write and read positions wrap modulo DEPTH, which may be any value of 4 or more. Order and data are preserved across any number of wraps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 2 | Write request per lane |
| wr_data0 | input | WIDTH | Write word, lane 0 |
| wr_data1 | input | WIDTH | Write word, lane 1 |
| rd_en | input | 2 | Read request per lane |
| rd_data0 | output | WIDTH | Read word, lane 0 (valid when rd_valid[0]) |
| rd_data1 | output | WIDTH | Read word, lane 1 (valid when rd_valid[1]) |
| rd_valid | output | 2 | Per-lane strobe for a returned word |
| empty | output | 2 | Per-lane: too few entries for this lane |
| full | output | 2 | Per-lane: too little room for this lane |
| rd_underrun | output | 1 | A read was requested on an empty lane |
| count | output | $clog2(DEPTH+1) | Number of stored entries |

## Verification
The assertions take nothing for granted about the request pattern. Any mix of enables is legal, including requests on blocked lanes, so the properties only assume a clean reset and inputs that settle before each edge. The bench changes enables and data at the falling edge only. It deliberately sends reads into an empty or nearly empty buffer and writes into a full or nearly full one, so the refusal paths run as often as the accepted paths. A long mixed stream then carries the ring positions through many wraps at a depth that is not a power of two.

// File: rtl/duo_fifo_pkg.sv
package duo_fifo_pkg;

  localparam int LANES = 2;

  // signed change of occupancy for one cycle of accepted traffic
  function automatic int net_delta(input logic [1:0] wr_acc, input logic [1:0] rd_acc);
    return int'(wr_acc[0]) + int'(wr_acc[1]) - int'(rd_acc[0]) - int'(rd_acc[1]);
  endfunction

  // ring position advance modulo an arbitrary depth (inc never exceeds 2)
  function automatic int unsigned ring_add(input int unsigned pos, input int unsigned inc,
                                           input int unsigned depth);
    int unsigned s;
    s = pos + inc;
    if (s >= depth) s = s - depth;
    return s;
  endfunction

endpackage

// File: rtl/duo_fifo_occ.sv
module duo_fifo_occ
  import duo_fifo_pkg::*;
#(
  parameter int DEPTH = 6,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    acc_w,
  input  logic [1:0]    acc_r,
  output logic [CW-1:0] cnt_q,
  output logic [1:0]    empty_q,
  output logic [1:0]    full_q
);

  logic [CW-1:0] cnt_d;
  logic          step_valid;
  logic          seen_q;

  always_comb begin
    step_valid = |{acc_w, acc_r};
    cnt_d      = cnt_q;
    if (step_valid) cnt_d = CW'(int'(cnt_q) + net_delta(acc_w, acc_r));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      seen_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      seen_q <= 1'b1;
    end
  end

  // per-lane flags registered from the next occupancy
  for (genvar i = 0; i < LANES; i++) begin : g_lane
    localparam logic [CW-1:0] EMPTY_AT = CW'(i);
    localparam logic [CW-1:0] FULL_AT  = CW'(DEPTH - i);
    logic e_q, f_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        e_q <= 1'b1;
        f_q <= 1'b0;
      end else begin
        e_q <= (cnt_d <= EMPTY_AT);
        f_q <= (cnt_d >= FULL_AT);
      end
    end
    assign empty_q[i] = e_q;
    assign full_q[i]  = f_q;
  end

  // R2: count moves by the accepted traffic of the previous cycle
  p_count_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    seen_q |-> int'(cnt_q) == int'($past(cnt_q)) + net_delta($past(acc_w), $past(acc_r)));

  // R3: occupancy stays within capacity
  p_cap_r3: assert property (@(posedge clk) disable iff (!rst_n) cnt_q <= CW'(DEPTH));

  // R3: registered flags agree with the registered count
  p_flag_match_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (empty_q[0] == (cnt_q == '0)) && (full_q[0] == (cnt_q == CW'(DEPTH))));

endmodule

// File: rtl/duo_fifo_ring.sv
module duo_fifo_ring
  import duo_fifo_pkg::*;
#(
  parameter int DEPTH = 6,
  parameter int WIDTH = 8,
  localparam int PW = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       acc_w,
  input  logic [WIDTH-1:0] wdata0,
  input  logic [WIDTH-1:0] wdata1,
  input  logic [1:0]       acc_r,
  output logic [WIDTH-1:0] rdata0,
  output logic [WIDTH-1:0] rdata1,
  output logic [1:0]       rvalid
);

  logic [WIDTH-1:0] mem_q [DEPTH];
  logic [PW-1:0]    wp_q, rp_q;
  logic [PW-1:0]    wa1, ra1, wp_d, rp_d;

  // lane 1 lands after lane 0 when lane 0 is also accepted
  always_comb begin
    wa1  = PW'(ring_add(32'(wp_q), 32'(acc_w[0]), DEPTH));
    ra1  = PW'(ring_add(32'(rp_q), 32'(acc_r[0]), DEPTH));
    wp_d = PW'(ring_add(32'(wp_q), 32'($countones(acc_w)), DEPTH));
    rp_d = PW'(ring_add(32'(rp_q), 32'($countones(acc_r)), DEPTH));
  end

  always_ff @(posedge clk) begin
    if (acc_w[0]) mem_q[wp_q] <= wdata0;
    if (acc_w[1]) mem_q[wa1]  <= wdata1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q   <= '0;
      rp_q   <= '0;
      rvalid <= '0;
      rdata0 <= '0;
      rdata1 <= '0;
    end else begin
      wp_q   <= wp_d;
      rp_q   <= rp_d;
      rvalid <= acc_r;
      if (acc_r[0]) rdata0 <= mem_q[rp_q];
      if (acc_r[1]) rdata1 <= mem_q[ra1];
    end
  end

  // R9: both ring positions stay inside the array
  p_ptr_range_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (32'(wp_q) < DEPTH) && (32'(rp_q) < DEPTH));

  // R7: two same-cycle writes never target one slot
  p_split_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (&acc_w) |-> (wa1 != wp_q));

endmodule

// File: rtl/duo_fifo.sv
module duo_fifo
  import duo_fifo_pkg::*;
#(
  parameter int DEPTH = 6,
  parameter int WIDTH = 8,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       wr_en,
  input  logic [WIDTH-1:0] wr_data0,
  input  logic [WIDTH-1:0] wr_data1,
  input  logic [1:0]       rd_en,
  output logic [WIDTH-1:0] rd_data0,
  output logic [WIDTH-1:0] rd_data1,
  output logic [1:0]       rd_valid,
  output logic [1:0]       empty,
  output logic [1:0]       full,
  output logic             rd_underrun,
  output logic [CW-1:0]    count
);

  // named lane events, visible to the assertions
  logic [1:0] wr_take, rd_take, rd_refuse;

  always_comb begin
    wr_take     = wr_en & ~full;
    rd_take     = rd_en & ~empty;
    rd_refuse   = rd_en & empty;
    rd_underrun = |rd_refuse;
  end

  duo_fifo_occ #(.DEPTH(DEPTH)) u_occ (
    .clk     (clk),
    .rst_n   (rst_n),
    .acc_w   (wr_take),
    .acc_r   (rd_take),
    .cnt_q   (count),
    .empty_q (empty),
    .full_q  (full)
  );

  duo_fifo_ring #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_ring (
    .clk    (clk),
    .rst_n  (rst_n),
    .acc_w  (wr_take),
    .wdata0 (wr_data0),
    .wdata1 (wr_data1),
    .acc_r  (rd_take),
    .rdata0 (rd_data0),
    .rdata1 (rd_data1),
    .rvalid (rd_valid)
  );

  // R4: with the buffer full and no reads, the count holds
  p_full_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (full[0] && rd_en == 2'b00) |=> $stable(count));

  // R5: a refused read yields no strobe next cycle
  p_empty_block0_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en[0] && empty[0]) |=> !rd_valid[0]);
  p_empty_block1_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en[1] && empty[1]) |=> !rd_valid[1]);

  // R6: underrun only occurs with at most one entry stored
  p_underrun_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rd_underrun |-> (count <= CW'(1)));

  // R8: a strobe always follows a request on that lane
  p_valid_req0_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid[0] |-> $past(rd_en[0]));
  p_valid_req1_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid[1] |-> $past(rd_en[1]));

endmodule

// File: tb/duo_fifo_tb.sv
`timescale 1ns/1ps
module duo_fifo_tb;

  localparam int D  = 6;
  localparam int W  = 8;
  localparam int CW = $clog2(D + 1);

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [1:0]    wr_en = '0, rd_en = '0;
  logic [W-1:0]  wr_data0 = '0, wr_data1 = '0;
  logic [W-1:0]  rd_data0, rd_data1;
  logic [1:0]    rd_valid, empty, full;
  logic          rd_underrun;
  logic [CW-1:0] count;

  always #4 clk = ~clk;

  duo_fifo #(.DEPTH(D), .WIDTH(W)) u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data0(wr_data0), .wr_data1(wr_data1),
    .rd_en(rd_en), .rd_data0(rd_data0), .rd_data1(rd_data1), .rd_valid(rd_valid),
    .empty(empty), .full(full), .rd_underrun(rd_underrun), .count(count)
  );

  int n_chk = 0, n_bad = 0;
  int mcount = 0;
  int nd = 1;
  string tag = "R7";
  logic [W-1:0] dq [$];
  logic [1:0]   vq [$];
  int           cq [$];

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // driver: one cycle of stimulus, model update, scoreboard push
  task automatic step(input logic [1:0] we, input logic [1:0] re);
    logic e0, e1, f0, f1;
    logic [1:0] aw, ar;
    @(negedge clk);
    wr_en = we; rd_en = re;
    wr_data0 = W'(nd); wr_data1 = W'(nd + 1); nd += 2;
    #1;
    e0 = (mcount <= 0); e1 = (mcount <= 1);
    f0 = (mcount >= D); f1 = (mcount >= D - 1);
    chk(empty === {e1, e0}, "R3", "empty", int'(empty), int'({e1, e0}));
    chk(full === {f1, f0}, "R3", "full", int'(full), int'({f1, f0}));
    chk(rd_underrun === |(re & {e1, e0}), "R6", "underrun", int'(rd_underrun), int'(|(re & {e1, e0})));
    aw = we & ~{f1, f0};
    ar = re & ~{e1, e0};
    if (aw[0]) dq.push_back(wr_data0);
    if (aw[1]) dq.push_back(wr_data1);
    mcount = mcount + int'(aw[0]) + int'(aw[1]) - int'(ar[0]) - int'(ar[1]);
    vq.push_back(ar);
    cq.push_back(mcount);
  endtask

  // monitor: compare results after each rising edge
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (rst_n && vq.size() > 0) begin
        logic [1:0] v;
        int c;
        v = vq.pop_front();
        c = cq.pop_front();
        chk(rd_valid === v, "R8", "rd_valid", int'(rd_valid), int'(v));
        chk(int'(count) == c, "R2", "count", int'(count), c);
        if (v[0]) begin
          logic [W-1:0] x;
          x = dq.pop_front();
          chk(rd_data0 === x, tag, "rd_data0", int'(rd_data0), int'(x));
        end
        if (v[1]) begin
          logic [W-1:0] x;
          x = dq.pop_front();
          chk(rd_data1 === x, tag, "rd_data1", int'(rd_data1), int'(x));
        end
      end
    end
  end

  initial begin
    #(8 * 200000);
    chk(1'b0, "WATCHDOG", "run did not finish", 0, 1);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: reset state
    chk(count === '0, "R1", "count", int'(count), 0);
    chk(empty === 2'b11, "R1", "empty", int'(empty), 3);
    chk(full === 2'b00, "R1", "full", int'(full), 0);
    chk(rd_valid === 2'b00, "R1", "rd_valid", int'(rd_valid), 0);
    chk(rd_underrun === 1'b0, "R1", "underrun", int'(rd_underrun), 0);
    rst_n = 1'b1;

    // R5 R6: reads into an empty buffer
    tag = "R5";
    step(2'b00, 2'b11);
    // R7: single-lane and dual-lane writes
    tag = "R7";
    step(2'b01, 2'b00);
    step(2'b10, 2'b00);
    step(2'b11, 2'b00);
    step(2'b00, 2'b11);
    step(2'b00, 2'b10);   // lane 1 alone takes the oldest
    // R5: lane 1 refused with one entry, then lane 0 gets that entry
    tag = "R5";
    step(2'b00, 2'b10);
    step(2'b00, 2'b01);
    // R4: fill, partial drop, full drop
    tag = "R4";
    step(2'b11, 2'b00);
    step(2'b11, 2'b00);
    step(2'b01, 2'b00);
    step(2'b11, 2'b00);
    step(2'b11, 2'b00);
    step(2'b11, 2'b11);
    step(2'b00, 2'b00);
    chk(mcount == D - 2, "R4", "model after drops", mcount, D - 2);
    // R9: long mixed stream through many wraps
    tag = "R9";
    for (int i = 0; i < 400; i++) begin
      step(2'(i ^ (i >> 2) ^ (i >> 5)), 2'((i >> 1) ^ (i >> 3) ^ 1));
    end
    for (int i = 0; i < 4; i++) step(2'b00, 2'b11);
    step(2'b00, 2'b00);
    step(2'b00, 2'b00);
    @(negedge clk);
    chk(vq.size() == 0, "R8", "pending results", vq.size(), 0);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule